// File: doc/BRIEF.md
# Legacy display address router

This block sits on the processor request path and sorts every memory or I/O request into one of two destinations: the graphics-attach port or the default downstream link. It recognises the legacy colour display windows and the legacy monochrome adapter windows. It applies the VGA-enable and monochrome-present configuration bits, the memory and I/O decode enables, and an I/O base/limit window that governs the printer-port corner of the legacy I/O map.

Each request arrives as a single-cycle strobe with an address, a memory/I/O flag and byte enables. For I/O requests the address names a dword. Each set byte enable adds one byte port to the set the request touches. The decision is registered and comes back one clock later as a one-hot code with its own valid strobe. Anything that hits no legacy range goes to the default link.

Top module: `lgdisp_router`

## Requirements
- R1: A response valid is raised in the clock cycle that follows each cycle in which the request valid is high, and in no other cycle.
- R2: The route output is 2'b10 for the graphics port and 2'b01 for the default link (bit 1 is graphics, bit 0 is default) while the response valid is high, and 2'b00 while it is low.
- R3: A synchronous active-high reset clears the response valid and the route output to 2'b00.
- R4: With VGA-enable clear, every request goes to the default link, whatever the monochrome-present bit says; the case of VGA-enable clear with monochrome-present set is treated the same way.
- R5: A memory request at byte address 0x0A0000 to 0x0BFFFF inclusive goes to the graphics port when VGA-enable and the memory enable are set and the monochrome carve-out of R6 does not apply; byte enables have no effect on memory decode.
- R6: A memory request at 0x0B0000 to 0x0B7FFF inclusive goes to the default link when VGA-enable and monochrome-present are both set, and to the graphics port when VGA-enable is set, monochrome-present is clear and the memory enable is set.
- R7: An I/O request whose enabled bytes touch port 0x3B0 to 0x3BB or 0x3C0 to 0x3DF goes to the graphics port when VGA-enable and the I/O enable are set and R8 does not apply; byte port n of a request is {address[15:2], n} for lane n, and only its low 10 bits are used in this match, so aliases with any value in bits [15:10] match too.
- R8: With VGA-enable and monochrome-present both set, an I/O request whose enabled bytes touch any of ports 0x3B4, 0x3B5, 0x3B8, 0x3B9, 0x3BA or 0x3BF, or a 10-bit alias of one, goes to the default link, even when its other bytes touch VGA ports.
- R9: An I/O request whose enabled bytes touch ports 0x3BC to 0x3BF (10-bit alias match) and which R8 does not claim goes to the graphics port only if VGA-enable and the I/O enable are set and the dword address {address[15:2], 2'b00} lies within base to limit inclusive; otherwise it goes to the default link.
- R10: With the memory enable clear, no memory request goes to the graphics port. With the I/O enable clear, no I/O request goes to the graphics port.
- R11: A request that touches no legacy range goes to the default link. This includes an I/O request with all byte enables clear and a memory request outside 0x0A0000 to 0x0BFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld_i | input | 1 | Request strobe |
| req_addr_i | input | ADDR_W | Request address (dword address for I/O) |
| req_is_io_i | input | 1 | 1 for I/O space, 0 for memory space |
| req_be_i | input | LANES | Byte enables, one per byte lane |
| cfg_vga_en_i | input | 1 | Legacy colour display forwarding enable |
| cfg_mono_en_i | input | 1 | Monochrome adapter present on the default link |
| cfg_mem_en_i | input | 1 | Memory decode enable for the graphics port |
| cfg_io_en_i | input | 1 | I/O decode enable for the graphics port |
| cfg_io_base_i | input | IO_W | Lower bound of the graphics I/O window |
| cfg_io_lim_i | input | IO_W | Upper bound of the graphics I/O window |
| rsp_vld_o | output | 1 | Decision valid, one cycle after the request |
| route_oh_o | output | 2 | One-hot route: bit 1 graphics port, bit 0 default link |

## Verification
The hardest situation to reach from the ports is a dword that mixes a monochrome port with a VGA port. Examples are 0x3B4 with 0x3B6, or the 0x3BF byte that belongs to both the monochrome set and the window-checked printer range. Reaching it needs the right byte-enable mix, both configuration bits set, and often an alias in address bits [15:10]. Random stimulus is therefore biased: I/O addresses are drawn mostly from 0x3B0 to 0x3DF with random alias bits, and the base/limit window is often set to cover the request. Directed cases pin the carve-out, the alias, the window edges and the enable gating.

// File: rtl/lgdisp_pkg.sv
package lgdisp_pkg;

  localparam int ALIAS_W = 10;
  typedef logic [ALIAS_W-1:0] port10_t;

  typedef enum logic [1:0] {
    RT_NONE = 2'b00,
    RT_DFLT = 2'b01,
    RT_GFX  = 2'b10
  } route_e;

  // Monochrome adapter byte ports (10-bit alias decode)
  function automatic logic is_mono_port(port10_t p);
    return p inside {10'h3B4, 10'h3B5, 10'h3B8, 10'h3B9, 10'h3BA, 10'h3BF};
  endfunction

  // Printer-port corner, routed by the base/limit window
  function automatic logic is_par_port(port10_t p);
    return (p >= 10'h3BC) && (p <= 10'h3BF);
  endfunction

  // Colour display ports, excluding the printer-port corner
  function automatic logic is_vga_port(port10_t p);
    return ((p >= 10'h3B0) && (p <= 10'h3BB)) ||
           ((p >= 10'h3C0) && (p <= 10'h3DF));
  endfunction

endpackage

// File: rtl/lgdisp_io_dec.sv
module lgdisp_io_dec
  import lgdisp_pkg::*;
#(
  parameter int IO_W  = 16,
  parameter int LANES = 4
) (
  input  logic [IO_W-1:0]  addr_i,
  input  logic [LANES-1:0] be_i,
  input  logic [IO_W-1:0]  base_i,
  input  logic [IO_W-1:0]  lim_i,
  output logic             mono_hit_o,
  output logic             vga_hit_o,
  output logic             par_hit_o,
  output logic             win_hit_o
);

  localparam int LB = $clog2(LANES);

  logic [LANES-1:0] lane_mono;
  logic [LANES-1:0] lane_vga;
  logic [LANES-1:0] lane_par;
  logic [IO_W-1:0]  dword_addr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IO_W-1:0] full_port;
    port10_t         alias_port;
    assign full_port  = {addr_i[IO_W-1:LB], LB'(g)};
    assign alias_port = full_port[ALIAS_W-1:0];
    assign lane_mono[g] = be_i[g] && is_mono_port(alias_port);
    assign lane_vga[g]  = be_i[g] && is_vga_port(alias_port);
    assign lane_par[g]  = be_i[g] && is_par_port(alias_port);
  end

  assign dword_addr = {addr_i[IO_W-1:LB], {LB{1'b0}}};

  assign mono_hit_o = |lane_mono;
  assign vga_hit_o  = |lane_vga;
  assign par_hit_o  = |lane_par;
  assign win_hit_o  = (dword_addr >= base_i) && (dword_addr <= lim_i);

endmodule

// File: rtl/lgdisp_mem_dec.sv
module lgdisp_mem_dec #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              vga_mem_o,
  output logic              mono_mem_o
);

  localparam logic [ADDR_W-1:0] VGA_LO  = ADDR_W'(20'hA0000);
  localparam logic [ADDR_W-1:0] VGA_HI  = ADDR_W'(20'hBFFFF);
  localparam logic [ADDR_W-1:0] MONO_LO = ADDR_W'(20'hB0000);
  localparam logic [ADDR_W-1:0] MONO_HI = ADDR_W'(20'hB7FFF);

  assign vga_mem_o  = (addr_i >= VGA_LO)  && (addr_i <= VGA_HI);
  assign mono_mem_o = (addr_i >= MONO_LO) && (addr_i <= MONO_HI);

endmodule

// File: rtl/lgdisp_route_sel.sv
module lgdisp_route_sel (
  input  logic is_io_i,
  input  logic vga_en_i,
  input  logic mono_en_i,
  input  logic mem_en_i,
  input  logic io_en_i,
  input  logic io_mono_i,
  input  logic io_vga_i,
  input  logic io_par_i,
  input  logic io_win_i,
  input  logic mem_vga_i,
  input  logic mem_mono_i,
  output logic carve_o,
  output logic gfx_o
);

  logic mono_active;
  logic claim;
  logic gate_ok;

  // VGA-enable clear forces the invalid combination to behave as plain disable
  assign mono_active = vga_en_i && mono_en_i;
  assign carve_o     = mono_active && (is_io_i ? io_mono_i : mem_mono_i);
  assign claim       = is_io_i ? (io_vga_i || (io_par_i && io_win_i)) : mem_vga_i;
  assign gate_ok     = is_io_i ? io_en_i : mem_en_i;
  assign gfx_o       = vga_en_i && !carve_o && gate_ok && claim;

endmodule

// File: rtl/lgdisp_router.sv
module lgdisp_router
  import lgdisp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IO_W   = 16,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_is_io_i,
  input  logic [LANES-1:0]  req_be_i,
  input  logic              cfg_vga_en_i,
  input  logic              cfg_mono_en_i,
  input  logic              cfg_mem_en_i,
  input  logic              cfg_io_en_i,
  input  logic [IO_W-1:0]   cfg_io_base_i,
  input  logic [IO_W-1:0]   cfg_io_lim_i,
  output logic              rsp_vld_o,
  output logic [1:0]        route_oh_o
);

  // Named decode events
  logic io_mono_hit, io_vga_hit, io_par_hit, io_win_hit;
  logic mem_vga_hit, mem_mono_hit;
  logic carve_hit, gfx_pick;
  route_e route_q;

  lgdisp_io_dec #(.IO_W(IO_W), .LANES(LANES)) u_io_dec (
    .addr_i     (req_addr_i[IO_W-1:0]),
    .be_i       (req_be_i),
    .base_i     (cfg_io_base_i),
    .lim_i      (cfg_io_lim_i),
    .mono_hit_o (io_mono_hit),
    .vga_hit_o  (io_vga_hit),
    .par_hit_o  (io_par_hit),
    .win_hit_o  (io_win_hit)
  );

  lgdisp_mem_dec #(.ADDR_W(ADDR_W)) u_mem_dec (
    .addr_i     (req_addr_i),
    .vga_mem_o  (mem_vga_hit),
    .mono_mem_o (mem_mono_hit)
  );

  lgdisp_route_sel u_sel (
    .is_io_i    (req_is_io_i),
    .vga_en_i   (cfg_vga_en_i),
    .mono_en_i  (cfg_mono_en_i),
    .mem_en_i   (cfg_mem_en_i),
    .io_en_i    (cfg_io_en_i),
    .io_mono_i  (io_mono_hit),
    .io_vga_i   (io_vga_hit),
    .io_par_i   (io_par_hit),
    .io_win_i   (io_win_hit),
    .mem_vga_i  (mem_vga_hit),
    .mem_mono_i (mem_mono_hit),
    .carve_o    (carve_hit),
    .gfx_o      (gfx_pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld_o <= 1'b0;
      route_q   <= RT_NONE;
    end else begin
      rsp_vld_o <= req_vld_i;
      route_q   <= !req_vld_i ? RT_NONE : (gfx_pick ? RT_GFX : RT_DFLT);
    end
  end

  assign route_oh_o = route_q;

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_vld_i |=> rsp_vld_o); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_vld_i |=> !rsp_vld_o); // R1
  AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    rsp_vld_o |-> ($countones(route_oh_o) == 1)); // R2
  AST_ROUTE_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rsp_vld_o |-> (route_oh_o == 2'b00)); // R2
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!rsp_vld_o && route_oh_o == 2'b00)); // R3
  AST_VGA_OFF_DFLT: assert property (@(posedge clk) disable iff (rst)
    (req_vld_i && !cfg_vga_en_i) |=> (route_oh_o == 2'b01)); // R4
  AST_MONO_CARVE: assert property (@(posedge clk) disable iff (rst)
    (req_vld_i && cfg_vga_en_i && cfg_mono_en_i && req_is_io_i && io_mono_hit)
    |=> (route_oh_o == 2'b01)); // R8
  AST_MEM_GATE: assert property (@(posedge clk) disable iff (rst)
    (req_vld_i && !req_is_io_i && !cfg_mem_en_i) |=> (route_oh_o == 2'b01)); // R10
  AST_IO_GATE: assert property (@(posedge clk) disable iff (rst)
    (req_vld_i && req_is_io_i && !cfg_io_en_i) |=> (route_oh_o == 2'b01)); // R10
  AST_BE_ZERO_DFLT: assert property (@(posedge clk) disable iff (rst)
    (req_vld_i && req_is_io_i && req_be_i == '0) |=> (route_oh_o == 2'b01)); // R11

endmodule

// File: tb/tb_lgdisp_router.sv
module tb_lgdisp_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_vld = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_io = 1'b0;
  logic [3:0]  req_be = '0;
  logic        c_vga = 1'b0, c_mono = 1'b0, c_memen = 1'b0, c_ioen = 1'b0;
  logic [15:0] c_base = '0, c_lim = '0;
  logic        rsp_vld;
  logic [1:0]  route;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [1:0] GFX = 2'b10;
  localparam logic [1:0] DFL = 2'b01;

  always #2 clk = ~clk;

  lgdisp_router dut (
    .clk(clk), .rst(rst), .req_vld_i(req_vld), .req_addr_i(req_addr),
    .req_is_io_i(req_io), .req_be_i(req_be), .cfg_vga_en_i(c_vga),
    .cfg_mono_en_i(c_mono), .cfg_mem_en_i(c_memen), .cfg_io_en_i(c_ioen),
    .cfg_io_base_i(c_base), .cfg_io_lim_i(c_lim),
    .rsp_vld_o(rsp_vld), .route_oh_o(route)
  );

  function automatic logic [1:0] model(logic io, logic [31:0] a, logic [3:0] be);
    logic mono_t, vga_t, par_t, win;
    logic [15:0] dw;
    logic [9:0] pp;
    mono_t = 1'b0; vga_t = 1'b0; par_t = 1'b0;
    dw = a[15:0] & 16'hFFFC;
    if (!c_vga) return DFL;
    if (io) begin
      for (int b = 0; b < 4; b++) begin
        if (be[b]) begin
          pp = dw[9:0] | 10'(b);
          case (pp)
            10'h3B4, 10'h3B5, 10'h3B8, 10'h3B9, 10'h3BA, 10'h3BF: mono_t = 1'b1;
            default: ;
          endcase
          if (pp >= 10'h3BC && pp <= 10'h3BF) par_t = 1'b1;
          else if ((pp >= 10'h3B0 && pp <= 10'h3BB) || (pp >= 10'h3C0 && pp <= 10'h3DF))
            vga_t = 1'b1;
        end
      end
      win = (dw >= c_base) && (dw <= c_lim);
      if (c_mono && mono_t) return DFL;
      if (!c_ioen) return DFL;
      if (vga_t || (par_t && win)) return GFX;
      return DFL;
    end else begin
      if (c_mono && a >= 32'hB0000 && a <= 32'hB7FFF) return DFL;
      if (!c_memen) return DFL;
      if (a >= 32'hA0000 && a <= 32'hBFFFF) return GFX;
      return DFL;
    end
  endfunction

  task automatic check(string tag, logic v_exp, logic [1:0] r_exp);
    checks++;
    if (rsp_vld !== v_exp || route !== r_exp) begin
      fails++;
      $display("FAIL %s: vld=%0b route=%b expected vld=%0b route=%b", tag, rsp_vld, route, v_exp, r_exp);
    end
  endtask

  task automatic set_cfg(logic v, logic m, logic me, logic ie, logic [15:0] b, logic [15:0] l);
    c_vga = v; c_mono = m; c_memen = me; c_ioen = ie; c_base = b; c_lim = l;
  endtask

  // Drive at a falling edge, sample at the next falling edge
  task automatic req(logic io, logic [31:0] a, logic [3:0] be, logic [1:0] exp, string tag);
    req_vld = 1'b1; req_io = io; req_addr = a; req_be = be;
    @(negedge clk);
    req_vld = 1'b0;
    check(tag, 1'b1, exp);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1D5A_7C03);
    repeat (3) @(negedge clk);
    check("R3 reset state", 1'b0, 2'b00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle", 1'b0, 2'b00);

    // R4
    set_cfg(0, 0, 1, 1, 16'h0000, 16'hFFFF);
    req(0, 32'hA0000, 4'hF, DFL, "R4 vga off mem");
    set_cfg(0, 1, 1, 1, 16'h0000, 16'hFFFF);
    req(1, 32'h3B4, 4'h1, DFL, "R4 invalid combo");
    req(1, 32'h3C0, 4'hF, DFL, "R4 invalid combo vga port");
    // R5 / R11 memory
    set_cfg(1, 0, 1, 1, 16'h0000, 16'hFFFF);
    req(0, 32'hA8000, 4'hF, GFX, "R5 mem mid");
    req(0, 32'hBFFFF, 4'h0, GFX, "R5 mem top, be ignored");
    req(0, 32'hA0000, 4'h1, GFX, "R5 mem bottom");
    @(negedge clk);
    check("R1 gap after burst", 1'b0, 2'b00);
    req(0, 32'hC0000, 4'hF, DFL, "R11 mem above");
    req(0, 32'h9FFFF, 4'hF, DFL, "R11 mem below");
    req(0, 32'h100A0000, 4'hF, DFL, "R11 mem high alias");
    // R6
    req(0, 32'hB4000, 4'hF, GFX, "R6 mono mem mdap0");
    set_cfg(1, 1, 1, 1, 16'h0000, 16'hFFFF);
    req(0, 32'hB4000, 4'hF, DFL, "R6 mono mem mdap1");
    req(0, 32'hB8000, 4'hF, GFX, "R6 just above mono");
    req(0, 32'hAFFFF, 4'hF, GFX, "R6 just below mono");
    // R7
    req(1, 32'h3D4, 4'h1, GFX, "R7 crtc port");
    req(1, 32'hFFD4, 4'h1, GFX, "R7 alias");
    req(1, 32'h3DC, 4'h8, GFX, "R7 top port 3DF");
    req(1, 32'h3E0, 4'h1, DFL, "R11 port 3E0");
    // R8
    req(1, 32'h3B4, 4'h4, GFX, "R8 3B6 alone");
    req(1, 32'h3B4, 4'h6, DFL, "R8 3B5 mixed with 3B6");
    req(1, 32'h7B4, 4'h2, DFL, "R8 alias 3B5");
    req(1, 32'h3BC, 4'h9, DFL, "R8 3BF with window");
    set_cfg(1, 0, 1, 1, 16'h0000, 16'hFFFF);
    req(1, 32'h3B4, 4'h6, GFX, "R8 mdap0 to graphics");
    // R9
    set_cfg(1, 0, 1, 1, 16'h03B0, 16'h03BF);
    req(1, 32'h3BC, 4'h1, GFX, "R9 in window");
    req(1, 32'h7BC, 4'h1, DFL, "R9 alias outside window");
    set_cfg(1, 0, 1, 1, 16'h03BC, 16'h03BC);
    req(1, 32'h3BC, 4'h8, GFX, "R9 window edge");
    set_cfg(1, 0, 1, 1, 16'h0400, 16'h0500);
    req(1, 32'h3BC, 4'h1, DFL, "R9 outside window");
    set_cfg(1, 1, 1, 1, 16'h03B0, 16'h03BF);
    req(1, 32'h3BC, 4'h2, GFX, "R9 mdap1 3BD in window");
    // R10
    set_cfg(1, 0, 0, 1, 16'h0000, 16'hFFFF);
    req(0, 32'hA0000, 4'hF, DFL, "R10 mem gate");
    req(1, 32'h3C0, 4'hF, GFX, "R10 io unaffected by mem gate");
    set_cfg(1, 0, 1, 0, 16'h0000, 16'hFFFF);
    req(1, 32'h3C0, 4'hF, DFL, "R10 io gate");
    req(0, 32'hA0000, 4'hF, GFX, "R10 mem unaffected by io gate");
    // R11
    set_cfg(1, 0, 1, 1, 16'h0000, 16'hFFFF);
    req(1, 32'h3C0, 4'h0, DFL, "R11 io no bytes");
    req(1, 32'h2F8, 4'hF, DFL, "R11 io non legacy");
    // R3 mid-run reset
    req_vld = 1'b1; req_io = 1'b1; req_addr = 32'h3C0; req_be = 4'hF; rst = 1'b1;
    @(negedge clk);
    req_vld = 1'b0; rst = 1'b0;
    check("R3 reset over request", 1'b0, 2'b00);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic io;
      logic [31:0] a;
      logic [3:0] be;
      logic [15:0] p16;
      io = $urandom % 2;
      be = 4'($urandom);
      set_cfg(1'($urandom), 1'($urandom), ($urandom % 4) != 0, ($urandom % 4) != 0,
              16'($urandom), 16'($urandom));
      if (io) begin
        if ($urandom % 4 != 0) begin
          p16 = {6'($urandom), 10'(10'h3B0 + ($urandom % 48))};
          a = {16'($urandom), p16};
          if ($urandom % 2 == 1) begin
            c_base = (p16 & 16'hFFFC) - 16'($urandom % 8);
            c_lim  = (p16 & 16'hFFFC) + 16'($urandom % 8);
          end
        end else a = $urandom;
      end else begin
        if ($urandom % 4 != 0) a = 32'h9F000 + ($urandom % 32'h22000);
        else a = $urandom;
      end
      req(io, a, be, model(io, a, be), !c_vga ? "R4 random" : (io ? "R7 random io" : "R5 random mem"));
      if ($urandom % 8 == 0) begin
        @(negedge clk);
        check("R2 random idle", 1'b0, 2'b00);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule